// File: doc/BRIEF.md
# Interruptible SDRAM Column Burst Sequencer

This block models the column side of a synchronous DRAM. A 256-word by 16-bit register array sits behind it, and it accepts column READ and WRITE commands. A READ passes through a delay line that is as deep as the programmed CAS latency. After that delay, the output stage streams the addressed burst onto the read-data port and raises an output-enable. When output-enable is low, the bus counts as high impedance.

A WRITE stores the word present in its own command cycle and then one word in each cycle that follows, until the burst ends. A newer command always wins over an older one:
- A later READ takes over the output stage once its own latency has run out. Only the words of the earlier burst that were already due before that point reach the bus.
- A later WRITE ends the running write burst immediately.
- A READ ends a write burst.
- A WRITE flushes every pending or streaming read.

Commands may arrive on every clock. Burst length and CAS latency are configuration inputs. They are held steady while any burst is pending or active.

Top module: `sdram_burst_seq`

## Requirements
- R1: A synchronous active-high reset drives `rd_oe` low on the next edge and discards every pending read, so no data appears afterwards for reads issued before or during reset.
- R2: With `cas_sel`=0 (latency 2) or 1 (latency 3), word 0 of a read issued at edge n is on `rd_data` with `rd_oe` high after edge n+2 or n+3 respectively.
- R3: `burst_sel` values 0,1,2,3 give bursts of 1,2,4,8 words, presented on consecutive cycles. `rd_oe` returns low after the last word unless another burst starts.
- R4: Word k of a burst addresses column (base with its low log2(BL) bits cleared) plus ((base+k) mod BL), so addresses wrap inside the aligned block.
- R5: A READ may follow a READ on every cycle. A newer read's first word replaces the older burst from that cycle on (BL=4, latency 2, reads one cycle apart: one word of the first, then four of the second).
- R6: A WRITE during a write burst ends the old burst at once, and the new burst writes from the new command's column.
- R7: Write data is stored on the command edge itself and on each following edge of the burst. WRITE commands may be issued every cycle.
- R8: A READ command ends an active write burst, and `wr_data` on that or later cycles is not stored for the old burst.
- R9: A WRITE command clears all pending and streaming reads, and `rd_oe` is low after that edge.
- R10: A READ issued one cycle after a WRITE to the same column returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| col_addr | input | 8 | Column address of the command |
| wr_data | input | 16 | Write data, sampled on command and burst edges |
| burst_sel | input | 2 | Burst length code: 0..3 means 1,2,4,8 |
| cas_sel | input | 1 | CAS latency: 0 means 2, 1 means 3 |
| rd_data | output | 16 | Read data |
| rd_oe | output | 1 | High while `rd_data` carries burst data |

## Verification
Two things can meet on the same edge. A read that is still in the latency line can reach its launch point on the very edge where a new command arrives: a WRITE must suppress the launch, and a later READ must take over the output from an older stream. Directed sequences place commands one, two and three cycles apart at both latencies to hit these collisions on purpose. Randomly spaced commands under random settings do the same at many more offsets. A bench scoreboard predicts, for every cycle, which column should be on the bus, or that the bus should be idle, and compares the output against its own memory image.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] col_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    burst_sel,
  input  logic          cas_sel,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [3:0]    blen;
  logic [AW-1:0] bmask;
  logic          wr_go, rd_go, wr_cont, rd_cont, launch;
  logic          wr_act;
  logic [AW-1:0] wr_base, rd_base, launch_col;
  logic [3:0]    wr_idx, rd_idx;
  logic [2:0]    pv;
  logic [AW-1:0] pa [3];

  assign blen  = 4'd1 << burst_sel;
  assign bmask = AW'(blen - 4'd1);
  assign wr_go = cmd_valid && cmd_write && !rst;
  assign rd_go = cmd_valid && !cmd_write && !rst;

  function automatic logic [AW-1:0] wrap_col(input logic [AW-1:0] base,
                                             input logic [3:0] idx,
                                             input logic [AW-1:0] m);
    return (base & ~m) | ((base + AW'(idx)) & m);
  endfunction

  assign wr_cont = wr_act && !cmd_valid && (wr_idx < blen);

  always_ff @(posedge clk) begin
    if (wr_go)
      mem[col_addr] <= wr_data;
    else if (wr_cont && !rst)
      mem[wrap_col(wr_base, wr_idx, bmask)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || rd_go) begin
      wr_act <= 1'b0;
    end else if (wr_go) begin
      wr_act  <= 1'b1;
      wr_base <= col_addr;
      wr_idx  <= 4'd1;
    end else if (wr_cont) begin
      wr_idx <= wr_idx + 4'd1;
    end else begin
      wr_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wr_go) pv <= '0;
    else              pv <= {pv[1:0], rd_go};
    pa[0] <= col_addr;
    pa[1] <= pa[0];
    pa[2] <= pa[1];
  end

  assign launch     = cas_sel ? pv[2] : pv[1];
  assign launch_col = cas_sel ? pa[2] : pa[1];
  assign rd_cont    = rd_oe && (rd_idx < blen);

  always_ff @(posedge clk) begin
    if (rst || wr_go) begin
      rd_oe <= 1'b0;
    end else if (launch) begin
      rd_data <= mem[launch_col];
      rd_oe   <= 1'b1;
      rd_base <= launch_col;
      rd_idx  <= 4'd1;
    end else if (rd_cont) begin
      rd_data <= mem[wrap_col(rd_base, rd_idx, bmask)];
      rd_idx  <= rd_idx + 4'd1;
    end else begin
      rd_oe <= 1'b0;
    end
  end
endmodule

module sdram_burst_seq_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_write,
  input logic cas_sel,
  input logic rd_oe
);
  logic rdc, wrc;
  assign rdc = cmd_valid && !cmd_write;
  assign wrc = cmd_valid && cmd_write;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !rd_oe);

  // R9
  write_flush_chk: assert property (@(posedge clk) disable iff (rst)
    wrc |=> !rd_oe);

  // R2
  lat_two_chk: assert property (@(posedge clk) disable iff (rst)
    (rdc && !cas_sel) ##1 !wrc ##1 !wrc |=> rd_oe);

  // R2
  lat_three_chk: assert property (@(posedge clk) disable iff (rst)
    (rdc && cas_sel) ##1 !wrc ##1 !wrc ##1 !wrc |=> rd_oe);
endmodule

bind sdram_burst_seq sdram_burst_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cas_sel(cas_sel), .rd_oe(rd_oe)
);

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb;
  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_write = 0, cas_sel = 0;
  logic [7:0] col_addr = 0;
  logic [15:0] wr_data = 0;
  logic [1:0] burst_sel = 0;
  logic [15:0] rd_data;
  logic rd_oe;

  always #4 clk = ~clk;

  sdram_burst_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .col_addr(col_addr), .wr_data(wr_data), .burst_sel(burst_sel),
    .cas_sel(cas_sel), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  logic [15:0] mm [256];
  logic ev [64];
  logic [7:0] ea [64];
  logic m_wact = 0;
  logic [7:0] m_wbase;
  int m_widx;

  function automatic logic [7:0] wcol(logic [7:0] b, int k, int bl);
    logic [7:0] m = 8'(bl - 1);
    return (b & ~m) | ((b + 8'(k)) & m);
  endfunction

  initial for (int i = 0; i < 64; i++) ev[i] = 0;

  // scoreboard model, updated on each edge from the requirements
  always @(posedge clk) begin
    int bl, cl;
    cyc++;
    bl = 1 << burst_sel;
    cl = cas_sel ? 3 : 2;
    if (rst) begin
      for (int i = 0; i < 64; i++) ev[i] = 0;
      m_wact = 0;
    end else if (cmd_valid && cmd_write) begin
      for (int i = 0; i < 16; i++) ev[(cyc + i) % 64] = 0;
      mm[col_addr] = wr_data;
      m_wact = 1; m_wbase = col_addr; m_widx = 1;
    end else if (cmd_valid) begin
      m_wact = 0;
      for (int i = 0; i < 16; i++) ev[(cyc + cl + i) % 64] = 0;
      for (int k = 0; k < bl; k++) begin
        ev[(cyc + cl + k) % 64] = 1;
        ea[(cyc + cl + k) % 64] = wcol(col_addr, k, bl);
      end
    end else if (m_wact && m_widx < bl) begin
      mm[wcol(m_wbase, m_widx, bl)] = wr_data;
      m_widx++;
    end else m_wact = 0;
  end

  always @(negedge clk) begin
    int s;
    s = cyc % 64;
    checks++;
    if (ev[s]) begin
      if (rd_oe !== 1'b1 || rd_data !== mm[ea[s]]) begin
        fails++;
        $display("FAIL %s cyc=%0d oe=%b data=%h expected oe=1 data=%h",
                 tag, cyc, rd_oe, rd_data, mm[ea[s]]);
      end
    end else if (rd_oe !== 1'b0) begin
      fails++;
      $display("FAIL %s cyc=%0d oe=%b expected oe=0", tag, cyc, rd_oe);
    end
    ev[s] = 0;
  end

  task automatic tick(input logic v, input logic w, input logic [7:0] a);
    cmd_valid = v; cmd_write = w; col_addr = a; wr_data = 16'($urandom);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk); @(negedge clk);
    // R1: outputs quiet under reset
    idle(3);
    rst = 0;
    // R7 preload with 8-word write bursts
    tag = "R7"; burst_sel = 3;
    for (int b = 0; b < 32; b++) begin tick(1, 1, 8'(b * 8)); idle(7); end
    idle(4);
    // R5: BL4 latency 2, reads one cycle apart
    tag = "R5"; burst_sel = 2; cas_sel = 0;
    tick(1, 0, 8'd5); tick(1, 0, 8'd20); idle(10);
    tick(1, 0, 8'd33); tick(1, 0, 8'd50); tick(1, 0, 8'd70); idle(12);
    // R4: wrap inside aligned block
    tag = "R4";
    tick(1, 0, 8'd7); idle(8);
    burst_sel = 3; tick(1, 0, 8'd13); idle(12);
    // R6: write interrupts write, then read both blocks back
    tag = "R6"; burst_sel = 2;
    tick(1, 1, 8'd40); tick(1, 1, 8'd66); idle(5);
    tick(1, 0, 8'd40); idle(1); tick(1, 0, 8'd64); idle(10);
    // R10: read right after write, latency 3
    tag = "R10"; cas_sel = 1; burst_sel = 0;
    tick(1, 1, 8'd100); tick(1, 0, 8'd100); idle(8);
    // R8: read ends an 8-word write burst
    tag = "R8"; burst_sel = 3;
    tick(1, 1, 8'd120); idle(2); tick(1, 0, 8'd200); idle(12);
    tick(1, 0, 8'd120); idle(14);
    // R9: write cancels pending and streaming reads
    tag = "R9"; burst_sel = 2;
    tick(1, 0, 8'd16); tick(1, 1, 8'd150); idle(10);
    tick(1, 0, 8'd16); idle(4); tick(1, 1, 8'd151); idle(10);
    cas_sel = 0;
    tick(1, 0, 8'd24); tick(0, 0, 0); tick(1, 1, 8'd152); idle(10);
    // R1: reset discards a pending read
    tag = "R1";
    tick(1, 0, 8'd30); rst = 1; tick(0, 0, 0); rst = 0; idle(8);
    // R2 R3: random spacing under random settings
    tag = "R2 R3";
    for (int seg = 0; seg < 24; seg++) begin
      burst_sel = 2'($urandom_range(0, 3));
      cas_sel = 1'($urandom_range(0, 1));
      for (int i = 0; i < 60; i++) begin
        if ($urandom_range(0, 9) < 3)
          tick(1, 1'($urandom_range(0, 3) == 0), 8'($urandom));
        else tick(0, 0, 0);
      end
      idle(14);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule